// File: doc/BRIEF.md
# Tiled 58-bit Unsigned Multiplier

This block multiplies two unsigned operands of up to 58 bits and returns the full 116-bit product through a short, fully pipelined datapath. The partial-product array is split into eight rectangular sub-products, each 17 by 24 bits. They are placed in an irregular pattern around a small 10-by-10 hole in the middle of the array. The hole is filled by one extra small multiply. Every partial-bit product is covered exactly once.

The eight rectangles form two groups of four. Each group is summed by a Horner-style chain in which the running sum is shifted left by 17 bits before the next product is added. The two chains run side by side. A final adder combines the low chain, the high chain (weighted 2^24) and the central product (weighted 2^48). A parameter sets whether this final three-way addition takes one pipeline stage or two. One operand pair can be accepted on every clock cycle. A 53-bit multiply is done by zero-extending both operands.

Top module: `m58_tiled_mul`

## Requirements
- R1: For any two 58-bit unsigned operands accepted with in_valid high, out_product equals their exact 116-bit product.
- R2: With FINAL_STAGES = 1, the result appears with out_valid high 4 clock edges after the edge that samples the operands. With FINAL_STAGES = 2, it appears 5 edges after.
- R3: out_valid is low during reset and stays low after reset until an accepted pair's result arrives. It is never high without a matching accepted pair.
- R4: A new pair can be accepted on every cycle. Results come out one per accepted pair, in acceptance order, including during back-to-back streams and streams with idle gaps.
- R5: If bits 57:53 of both operands are zero (53-bit operands, zero-extended), then bits 115:106 of the product are zero.
- R6: If both operands have set bits only in positions 33:24, the product is correct and has set bits only in positions 67:48.
- R7: out_product keeps its value in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | High when in_a and in_b hold an operand pair to multiply |
| in_a | input | 58 | First unsigned operand |
| in_b | input | 58 | Second unsigned operand |
| out_valid | output | 1 | High for one cycle per finished product |
| out_product | output | 116 | Unsigned product of the pair; held while out_valid is low |

## Verification
The bench builds two copies of the block on the same stimulus. One uses a single-stage final adder and the other a two-stage final adder, so both latencies and both versions of the final sum are exercised. A single walking one on one operand, with the other operand all ones, touches every tile row and column on its own. Operands restricted to the central bit range leave all eight rectangles at zero and drive only the small central multiply.

// File: rtl/m58_mul_pkg.sv
package m58_mul_pkg;
  localparam int OPW         = 58;
  localparam int PRW         = 2 * OPW;
  localparam int NARROW_W    = 53;
  localparam int STEP        = 17;
  localparam int NTILE       = 8;
  localparam int CHAIN_LEN   = NTILE / 2;
  localparam int CHAIN2_BASE = 24;
  localparam int TILE_PW     = 41;
  localparam int HOLE_LO     = 24;
  localparam int HOLE_W      = 10;
  localparam int HOLE_PW     = 2 * HOLE_W;
  localparam int HOLE_BASE   = 2 * HOLE_LO;

  typedef logic [OPW-1:0]     opnd_t;
  typedef logic [PRW-1:0]     prod_t;
  typedef logic [TILE_PW-1:0] tile_prod_t;
  typedef logic [HOLE_PW-1:0] hole_prod_t;

  localparam opnd_t HOLE_OMASK = opnd_t'(((64'd1 << HOLE_W) - 64'd1) << HOLE_LO);
  localparam prod_t HOLE_PMASK = prod_t'(((128'd1 << HOLE_PW) - 128'd1) << HOLE_BASE);

  // tiles 0..3 feed the low chain, 4..7 the high chain; index = step within chain
  function automatic int tile_xlo(input int idx);
    int r;
    case (idx)
      0, 1, 2: r = 0;
      3:       r = 17;
      4:       r = 24;
      5:       r = 41;
      default: r = 34;
    endcase
    return r;
  endfunction

  function automatic int tile_xw(input int idx);
    int r;
    case (idx)
      0, 1, 6, 7: r = 24;
      default:    r = 17;
    endcase
    return r;
  endfunction

  function automatic int tile_ylo(input int idx);
    int r;
    case (idx)
      1:       r = 17;
      2, 3:    r = 34;
      6:       r = 24;
      7:       r = 41;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic int tile_yw(input int idx);
    int r;
    case (idx)
      0, 1, 6, 7: r = 17;
      default:    r = 24;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/m58_tile.sv
module m58_tile #(
  parameter int XW = 24,
  parameter int YW = 17,
  parameter int PW = 41
) (
  input  logic          clk,
  input  logic          en,
  input  logic [XW-1:0] xs,
  input  logic [YW-1:0] ys,
  output logic [PW-1:0] p
);
  logic [PW-1:0] p_nx;

  always_comb begin
    p_nx = PW'(xs) * PW'(ys);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      p <= p_nx;
    end
  end
endmodule

// File: rtl/m58_chain.sv
module m58_chain
  import m58_mul_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  tile_prod_t [CHAIN_LEN-1:0]      prods,
  output prod_t                           sum
);
  prod_t sum_nx;

  // Horner form: highest-weight product first, shift by STEP before each add
  always_comb begin
    sum_nx = '0;
    for (int k = CHAIN_LEN - 1; k >= 0; k--) begin
      sum_nx = (sum_nx << STEP) + prod_t'(prods[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum <= sum_nx;
    end
  end

  AST_CHAIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && prods == '0) |=> (sum == '0)); // R1
endmodule

// File: rtl/m58_final.sv
module m58_final
  import m58_mul_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  prod_t      lo,
  input  prod_t      hi,
  input  hole_prod_t hole,
  output logic       out_valid,
  output prod_t      out_sum
);
  generate
    if (STAGES == 1) begin : g_one
      prod_t sum_nx;
      logic  vld_nx;

      always_comb begin
        sum_nx = lo + (hi << CHAIN2_BASE) + (prod_t'(hole) << HOLE_BASE);
        vld_nx = en;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= vld_nx;
      end

      always_ff @(posedge clk) begin
        if (en) out_sum <= sum_nx;
      end
    end else begin : g_two
      prod_t part_nx, part_q, hi_q, sum_nx;
      logic  part_v;

      always_comb begin
        part_nx = lo + (prod_t'(hole) << HOLE_BASE);
        sum_nx  = part_q + (hi_q << CHAIN2_BASE);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          part_v    <= 1'b0;
          out_valid <= 1'b0;
        end else begin
          part_v    <= en;
          out_valid <= part_v;
        end
      end

      always_ff @(posedge clk) begin
        if (en) begin
          part_q <= part_nx;
          hi_q   <= hi;
        end
        if (part_v) out_sum <= sum_nx;
      end
    end
  endgenerate

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sum)); // R7
endmodule

// File: rtl/m58_tiled_mul.sv
module m58_tiled_mul
  import m58_mul_pkg::*;
#(
  parameter int FINAL_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             out_valid,
  output logic [PRW-1:0]   out_product
);
  localparam int LAT = 3 + FINAL_STAGES;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // valid pipeline: [0] operands held, [1] products held, [2] chain sums held
  logic [2:0] vpipe_q, vpipe_nx;
  always_comb begin
    vpipe_nx = {vpipe_q[1:0], in_valid};
  end
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) vpipe_q <= '0;
    else           vpipe_q <= vpipe_nx;
  end

  opnd_t a_q, b_q;
  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_q <= in_a;
      b_q <= in_b;
    end
  end

  tile_prod_t [NTILE-1:0] tp;
  for (genvar g = 0; g < NTILE; g++) begin : g_tile
    localparam int XLO = tile_xlo(g);
    localparam int XW  = tile_xw(g);
    localparam int YLO = tile_ylo(g);
    localparam int YW  = tile_yw(g);
    m58_tile #(.XW(XW), .YW(YW), .PW(TILE_PW)) u_tile (
      .clk (clk),
      .en  (vpipe_q[0]),
      .xs  (a_q[XLO +: XW]),
      .ys  (b_q[YLO +: YW]),
      .p   (tp[g])
    );
  end

  hole_prod_t hole_p, hole_q;
  m58_tile #(.XW(HOLE_W), .YW(HOLE_W), .PW(HOLE_PW)) u_hole (
    .clk (clk),
    .en  (vpipe_q[0]),
    .xs  (a_q[HOLE_LO +: HOLE_W]),
    .ys  (b_q[HOLE_LO +: HOLE_W]),
    .p   (hole_p)
  );
  always_ff @(posedge clk) begin
    if (vpipe_q[1]) hole_q <= hole_p;
  end

  prod_t chain_lo, chain_hi;
  m58_chain u_chain_lo (
    .clk   (clk),
    .rst_n (rst_sync),
    .en    (vpipe_q[1]),
    .prods (tp[CHAIN_LEN-1:0]),
    .sum   (chain_lo)
  );
  m58_chain u_chain_hi (
    .clk   (clk),
    .rst_n (rst_sync),
    .en    (vpipe_q[1]),
    .prods (tp[NTILE-1:CHAIN_LEN]),
    .sum   (chain_hi)
  );

  m58_final #(.STAGES(FINAL_STAGES)) u_final (
    .clk       (clk),
    .rst_n     (rst_sync),
    .en        (vpipe_q[2]),
    .lo        (chain_lo),
    .hi        (chain_hi),
    .hole      (hole_q),
    .out_valid (out_valid),
    .out_sum   (out_product)
  );

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, LAT)); // R2

  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_a[OPW-1:NARROW_W] == '0 && in_b[OPW-1:NARROW_W] == '0, LAT))
    |-> (out_product[PRW-1:2*NARROW_W] == '0)); // R5

  AST_HOLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(((in_a & ~HOLE_OMASK) == '0) && ((in_b & ~HOLE_OMASK) == '0), LAT))
    |-> ((out_product & ~HOLE_PMASK) == '0)); // R6
endmodule

// File: tb/tb_m58_tiled_mul.sv
module tb_m58_tiled_mul;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 58;
  localparam int PW         = 116;
  localparam int LAT_A      = 4;
  localparam int LAT_B      = 5;

  typedef logic [W-1:0]  op_t;
  typedef logic [PW-1:0] pr_t;

  localparam op_t ALL1   = {W{1'b1}};
  localparam op_t CENTRE = op_t'(58'h3FF) << 24;
  localparam op_t LOW53  = (op_t'(1) << 53) - op_t'(1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  op_t  in_a = '0, in_b = '0;
  logic ov_a, ov_b;
  pr_t  op_a, op_b;
  int   cyc = 0, total = 0, bad = 0;
  bit   done = 1'b0;

  pr_t   qa_p[$], qb_p[$];
  int    qa_c[$], qb_c[$];
  string qa_t[$], qb_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  m58_tiled_mul #(.FINAL_STAGES(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(ov_a), .out_product(op_a));

  m58_tiled_mul #(.FINAL_STAGES(2)) dut_deep (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(ov_b), .out_product(op_b));

  task automatic check(input bit ok, input string tag, input pr_t act, input pr_t exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic op_t rnd();
    return op_t'({$urandom(), $urandom()});
  endfunction

  task automatic send(input op_t a, input op_t b, input string tag);
    pr_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    e = pr_t'(a) * pr_t'(b);
    qa_p.push_back(e); qa_c.push_back(cyc); qa_t.push_back(tag);
    qb_p.push_back(e); qb_c.push_back(cyc); qb_t.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    pr_t e; int c0; string t;
    if (rst_n && ov_a) begin
      if (qa_p.size() == 0) check(1'b0, "R3 unexpected valid (single)", op_a, '0);
      else begin
        e = qa_p.pop_front(); c0 = qa_c.pop_front(); t = qa_t.pop_front();
        check(op_a == e, {t, " (single)"}, op_a, e);
        check(cyc - c0 == LAT_A, "R2 latency (single)", pr_t'(cyc - c0), pr_t'(LAT_A));
      end
    end
  end

  always @(negedge clk) begin
    pr_t e; int c0; string t;
    if (rst_n && ov_b) begin
      if (qb_p.size() == 0) check(1'b0, "R3 unexpected valid (two-stage)", op_b, '0);
      else begin
        e = qb_p.pop_front(); c0 = qb_c.pop_front(); t = qb_t.pop_front();
        check(op_b == e, {t, " (two-stage)"}, op_b, e);
        check(cyc - c0 == LAT_B, "R2 latency (two-stage)", pr_t'(cyc - c0), pr_t'(LAT_B));
      end
    end
  end

  initial begin
    pr_t hold_a, hold_b;
    repeat (3) @(negedge clk);
    check(!ov_a && !ov_b, "R3 valid low in reset", pr_t'({ov_a, ov_b}), '0);
    rst_n = 1'b1;
    idle(5);
    check(!ov_a && !ov_b, "R3 valid low after reset", pr_t'({ov_a, ov_b}), '0);

    send('0, '0, "R1 zero");
    send(ALL1, ALL1, "R1 max*max");
    send(ALL1, op_t'(1), "R1 max*1");
    send(op_t'(1), ALL1, "R1 1*max");
    idle(3);
    for (int i = 0; i < W; i++) send(op_t'(1) << i, ALL1, "R1 walking bit on a");
    for (int i = 0; i < W; i++) send(ALL1, op_t'(1) << i, "R1 walking bit on b");

    send(CENTRE, CENTRE, "R6 centre full");
    for (int i = 0; i < 20; i++) send(rnd() & CENTRE, rnd() & CENTRE, "R6 centre random");
    idle(8);

    hold_a = op_a;
    hold_b = op_b;
    idle(6);
    check(op_a == hold_a, "R7 hold while idle (single)", op_a, hold_a);
    check(op_b == hold_b, "R7 hold while idle (two-stage)", op_b, hold_b);

    send(LOW53, LOW53, "R5 53-bit max");
    for (int i = 0; i < 30; i++) send(rnd() & LOW53, rnd() & LOW53, "R5 53-bit random");

    for (int i = 0; i < 200; i++) send(rnd(), rnd(), "R4 back-to-back");
    for (int i = 0; i < 100; i++) begin
      send(rnd(), rnd(), "R4 gapped stream");
      if ($urandom_range(2) == 0) idle(1 + $urandom_range(3));
    end
    idle(12);
    check(qa_p.size() == 0, "R4 all results delivered (single)", pr_t'(qa_p.size()), '0);
    check(qb_p.size() == 0, "R4 all results delivered (two-stage)", pr_t'(qb_p.size()), '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      repeat (50000) @(posedge clk);
    join_any
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule